// File: doc/BRIEF.md
# Half-Digit LCD Segment Driver

This block accepts a signed conversion result and turns it into the drive signals for a three-and-a-half digit seven-segment liquid-crystal panel. The units, tens and hundreds positions each drive seven segment lines. The leading position can only show a "1", and a single line lights both bars of that "1". A further line lights the minus sign. The block divides the system clock to make a square-wave backplane for the panel's common electrode. Each segment line is then driven in antiphase to the backplane when the segment is lit and in phase when it is dark, so a lit segment sees AC drive with no DC component.

A new result is captured only on the cycle its valid strobe is high. Between strobes the panel keeps showing the last captured value. The magnitude is converted from binary to decimal digits. Leading zeros in the hundreds and tens positions are blanked. A magnitude above full scale is shown as an overrange indication. A lamp-test input lights every line at once and leaves the captured result untouched.

Top module: `lcdh_drv`

## Requirements
- R1: After reset is released, the backplane `bp_out` is low and toggles at every HALF_CYC-th rising clock edge (default 4). The first toggle is at the HALF_CYC-th edge, which gives a 50% duty square wave with a period of 2*HALF_CYC cycles.
- R2: Every segment line, including `seg_one` and `seg_minus`, equals `~bp_out` when its segment is lit and equals `bp_out` when it is dark.
- R3: `res_neg` and `res_mag` are captured at a rising edge where `res_valid` is high, and the lines reflect the captured value right after that edge. Input changes without `res_valid` have no effect on the lines.
- R4: `seg_minus` is lit exactly when the captured `res_neg` is 1. This includes a magnitude of zero and an overrange result.
- R5: While `lamp_test` is high, all 23 lines are lit in the same cycle. Dropping `lamp_test` restores the captured display. A result strobed while `lamp_test` is high is still captured.
- R6: Segment vectors use bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g. Digits 0..9 light, in order: abcdef, bc, abdeg, abcdg, bcfg, acdfg, acdefg, abc, abcdefg, abcdfg.
- R7: A magnitude above MAX_COUNT (default 1999) lights `seg_one` and blanks the units, tens and hundreds positions.
- R8: For magnitudes 1000..MAX_COUNT, `seg_one` is lit and the lower three positions show the remaining digits. Below 1000, `seg_one` is dark.
- R9: The hundreds position is blank when the magnitude is below 100, and the tens position is blank when it is below 10. The units position always shows a digit, so 0 shows "0".
- R10: During and after reset, before any strobe, every line is dark (equal to `bp_out`), and `bp_out` is low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Capture strobe for a new result |
| res_neg | input | 1 | Sign of the result, 1 = negative |
| res_mag | input | MAG_W (11) | Unsigned magnitude of the result |
| lamp_test | input | 1 | Light every segment and the sign |
| bp_out | output | 1 | Backplane square wave |
| seg_units | output | 7 | Units position lines, bit 0 = a .. bit 6 = g |
| seg_tens | output | 7 | Tens position lines |
| seg_hund | output | 7 | Hundreds position lines |
| seg_one | output | 1 | Both bars of the leading "1" |
| seg_minus | output | 1 | Minus sign line |

## Verification
A result strobe and lamp test can fall on the same cycle. In that cycle the override must win on the lines while the new result is still captured underneath it. The bench raises `res_valid` and `lamp_test` together and checks that all lines are lit after the edge. It then drops the lamp test and checks that the freshly strobed value, not the earlier one, appears. The full magnitude range of the default 11-bit width is swept with both signs, so every digit pattern, blanking case and overrange value is compared against decimal arithmetic done in the bench, at whatever backplane phase it happens to land on.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;

    localparam int SEG_N   = 7;
    localparam int DIG_N   = 3;
    localparam int LINE_N  = SEG_N * DIG_N + 2;
    localparam int BCD_IN  = 16;
    localparam int BCD_DIG = 4;

    typedef logic [SEG_N-1:0] seg7_t;
    typedef logic [3:0]       bcd_t;

    // Lit pattern for the whole panel; packed so neg is the top line.
    typedef struct packed {
        logic                   neg;
        logic                   one;
        seg7_t [DIG_N-1:0]      dig;   // [2] hundreds, [1] tens, [0] units
    } lit_t;

    // Seven-segment pattern, bit 0 = a .. bit 6 = g.
    function automatic seg7_t seg7_of(input bcd_t d);
        seg7_t s;
        case (d)
            4'd0:    s = 7'b011_1111;
            4'd1:    s = 7'b000_0110;
            4'd2:    s = 7'b101_1011;
            4'd3:    s = 7'b100_1111;
            4'd4:    s = 7'b110_0110;
            4'd5:    s = 7'b110_1101;
            4'd6:    s = 7'b111_1101;
            4'd7:    s = 7'b000_0111;
            4'd8:    s = 7'b111_1111;
            4'd9:    s = 7'b110_1111;
            default: s = 7'b000_0000;
        endcase
        return s;
    endfunction

    // Shift-and-add-3 binary to decimal conversion, four decimal digits.
    function automatic logic [4*BCD_DIG-1:0] bin_to_bcd(input logic [BCD_IN-1:0] v);
        logic [4*BCD_DIG-1:0] acc;
        acc = '0;
        for (int i = BCD_IN - 1; i >= 0; i--) begin
            for (int k = 0; k < BCD_DIG; k++) begin
                if (acc[4*k +: 4] >= 4'd5)
                    acc[4*k +: 4] = acc[4*k +: 4] + 4'd3;
            end
            acc = {acc[4*BCD_DIG-2:0], v[i]};
        end
        return acc;
    endfunction

endpackage

// File: rtl/lcdh_bp_gen.sv
module lcdh_bp_gen #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    output logic bp
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            bp  <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            bp  <= ~bp;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcdh_result_latch.sv
module lcdh_result_latch
    import lcdh_pkg::*;
#(
    parameter int MAG_W     = 11,
    parameter int MAX_COUNT = 1999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             neg,
    input  logic [MAG_W-1:0] mag,
    output lit_t             disp
);
    localparam logic [MAG_W-1:0] MAX_V   = MAG_W'(MAX_COUNT);
    localparam logic [MAG_W-1:0] TEN_V   = MAG_W'(10);
    localparam logic [MAG_W-1:0] HUND_V  = MAG_W'(100);

    logic [4*BCD_DIG-1:0] bcd;
    logic                 over;
    lit_t                 nxt;

    always_comb begin
        bcd  = bin_to_bcd(BCD_IN'(mag));
        over = (mag > MAX_V);
        nxt.neg = neg;
        if (over) begin
            nxt.one = 1'b1;
            nxt.dig = '0;
        end else begin
            nxt.one    = (bcd[15:12] == 4'd1);
            nxt.dig[0] = seg7_of(bcd[3:0]);
            nxt.dig[1] = (mag >= TEN_V)  ? seg7_of(bcd[7:4])  : '0;
            nxt.dig[2] = (mag >= HUND_V) ? seg7_of(bcd[11:8]) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            disp <= '0;
        else if (valid)
            disp <= nxt;
    end
endmodule

// File: rtl/lcdh_seg_drive.sv
module lcdh_seg_drive #(
    parameter int N = 23
) (
    input  logic         bp,
    input  logic         lamp,
    input  logic [N-1:0] lit,
    output logic [N-1:0] drv
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign drv[i] = (lit[i] | lamp) ? ~bp : bp;
    end
endmodule

// File: rtl/lcdh_drv.sv
module lcdh_drv
    import lcdh_pkg::*;
#(
    parameter int MAG_W     = 11,
    parameter int MAX_COUNT = 1999,
    parameter int HALF_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic             res_neg,
    input  logic [MAG_W-1:0] res_mag,
    input  logic             lamp_test,
    output logic             bp_out,
    output logic [6:0]       seg_units,
    output logic [6:0]       seg_tens,
    output logic [6:0]       seg_hund,
    output logic             seg_one,
    output logic             seg_minus
);
    lit_t              disp;
    logic [LINE_N-1:0] drv;

    lcdh_bp_gen #(.HALF_CYC(HALF_CYC)) u_bp (
        .clk (clk),
        .rst (rst),
        .bp  (bp_out)
    );

    lcdh_result_latch #(.MAG_W(MAG_W), .MAX_COUNT(MAX_COUNT)) u_lat (
        .clk   (clk),
        .rst   (rst),
        .valid (res_valid),
        .neg   (res_neg),
        .mag   (res_mag),
        .disp  (disp)
    );

    lcdh_seg_drive #(.N(LINE_N)) u_drv (
        .bp   (bp_out),
        .lamp (lamp_test),
        .lit  (disp),
        .drv  (drv)
    );

    assign seg_units = drv[6:0];
    assign seg_tens  = drv[13:7];
    assign seg_hund  = drv[20:14];
    assign seg_one   = drv[21];
    assign seg_minus = drv[22];
endmodule

// File: rtl/lcdh_chk.sv
module lcdh_chk #(
    parameter int MAG_W     = 11,
    parameter int MAX_COUNT = 1999,
    parameter int HALF_CYC  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             res_valid,
    input logic             res_neg,
    input logic [MAG_W-1:0] res_mag,
    input logic             lamp_test,
    input logic             bp_out,
    input logic [6:0]       seg_units,
    input logic [6:0]       seg_tens,
    input logic [6:0]       seg_hund,
    input logic             seg_one,
    input logic             seg_minus
);
    localparam logic [MAG_W-1:0] MAX_V = MAG_W'(MAX_COUNT);

    logic [22:0] lines;
    assign lines = {seg_minus, seg_one, seg_hund, seg_tens, seg_units};

    // Run length of the backplane level, saturating.
    logic bp_d;
    int   run;
    always_ff @(posedge clk) begin
        if (rst) begin
            bp_d <= 1'b0;
            run  <= 0;
        end else begin
            bp_d <= bp_out;
            if (bp_out != bp_d) run <= 0;
            else if (run < 1000) run <= run + 1;
        end
    end

    p_bp_run_r1: assert property (@(posedge clk) disable iff (rst)
        run <= HALF_CYC);

    p_lamp_all_r5: assert property (@(posedge clk) disable iff (rst)
        lamp_test |-> (lines == {23{~bp_out}}));

    p_overrange_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_mag > MAX_V)) |=>
            (lamp_test || ({seg_hund, seg_tens, seg_units} == {21{bp_out}} && seg_one != bp_out)));

    p_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_neg) |=> (seg_minus != bp_out));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !lamp_test && !$past(res_valid) && !$past(rst)) |=>
            (lamp_test || $stable(lines ^ {23{bp_out}})));

    p_reset_dark_r10: assert property (@(posedge clk)
        $past(rst) |-> (lines == {23{bp_out}}));
endmodule

bind lcdh_drv lcdh_chk #(.MAG_W(MAG_W), .MAX_COUNT(MAX_COUNT), .HALF_CYC(HALF_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .res_valid (res_valid),
    .res_neg   (res_neg),
    .res_mag   (res_mag),
    .lamp_test (lamp_test),
    .bp_out    (bp_out),
    .seg_units (seg_units),
    .seg_tens  (seg_tens),
    .seg_hund  (seg_hund),
    .seg_one   (seg_one),
    .seg_minus (seg_minus)
);

// File: tb/sim_lcdh_drv.sv
`timescale 1ns/1ps
module sim_lcdh_drv;
    localparam int MAG_W = 11;
    localparam int HALF  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             res_valid = 1'b0;
    logic             res_neg = 1'b0;
    logic [MAG_W-1:0] res_mag = '0;
    logic             lamp_test = 1'b0;
    logic             bp_out;
    logic [6:0]       seg_units, seg_tens, seg_hund;
    logic             seg_one, seg_minus;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    lcdh_drv #(.MAG_W(MAG_W), .MAX_COUNT(1999), .HALF_CYC(HALF)) u0 (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_neg(res_neg),
        .res_mag(res_mag), .lamp_test(lamp_test), .bp_out(bp_out),
        .seg_units(seg_units), .seg_tens(seg_tens), .seg_hund(seg_hund),
        .seg_one(seg_one), .seg_minus(seg_minus)
    );

    // R6 patterns, bit 0 = a .. bit 6 = g
    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    function automatic logic [22:0] expect_lit(input logic neg, input int mag);
        logic [6:0] u, t, h;
        if (mag > 1999) return {neg, 1'b1, 21'b0};
        u = pat(mag % 10);
        t = (mag >= 10)  ? pat((mag / 10) % 10)  : 7'h00;
        h = (mag >= 100) ? pat((mag / 100) % 10) : 7'h00;
        return {neg, (mag >= 1000), h, t, u};
    endfunction

    task automatic check_lit(input string req, input logic [22:0] exp_v);
        logic [22:0] act;
        act = {seg_minus, seg_one, seg_hund, seg_tens, seg_units} ^ {23{bp_out}};
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp_v);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp_v);
        end
    endtask

    task automatic strobe(input logic neg, input int mag, input logic lamp);
        res_valid = 1'b1; res_neg = neg; res_mag = MAG_W'(mag); lamp_test = lamp;
        @(posedge clk); @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R10 bp low in reset", bp_out, 1'b0);
        check_lit("R10 dark in reset", 23'h0);

        // R1: backplane phase after release
        rst = 1'b0;
        for (int k = 1; k <= 5 * HALF; k++) begin
            @(posedge clk); @(negedge clk);
            check_bit("R1 backplane", bp_out, logic'((k / HALF) % 2));
            if (k == 1) check_lit("R10 dark after reset", 23'h0);
        end

        // R2 R4 R6 R7 R8 R9: full sweep, both signs
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < (1 << MAG_W); m++) begin
                strobe(logic'(s), m, 1'b0);
                check_lit("R2 R4 R6 R7 R8 R9 sweep", expect_lit(logic'(s), m));
            end
        end

        // R3: inputs change without strobe
        strobe(1'b0, 1234, 1'b0);
        res_neg = 1'b1; res_mag = MAG_W'(567);
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            check_lit("R3 hold without strobe", expect_lit(1'b0, 1234));
        end

        // R5: lamp alone, then restore
        lamp_test = 1'b1;
        #0;
        check_lit("R5 lamp same cycle", {23{1'b1}});
        @(posedge clk); @(negedge clk);
        check_lit("R5 lamp held", {23{1'b1}});
        lamp_test = 1'b0;
        #0;
        check_lit("R5 restore after lamp", expect_lit(1'b0, 1234));

        // R5 with R3: strobe and lamp on the same cycle
        strobe(1'b1, 890, 1'b1);
        check_lit("R5 lamp with strobe", {23{1'b1}});
        lamp_test = 1'b0;
        #0;
        check_lit("R5 R3 strobe captured under lamp", expect_lit(1'b1, 890));
        for (int k = 0; k < 2 * HALF; k++) begin
            @(posedge clk); @(negedge clk);
            check_lit("R2 both phases", expect_lit(1'b1, 890));
        end

        // R4 R7: negative zero and negative overrange
        strobe(1'b1, 0, 1'b0);
        check_lit("R4 negative zero", {1'b1, 1'b0, 14'h0, 7'h3F});
        strobe(1'b1, 2000, 1'b0);
        check_lit("R7 overrange edge", {1'b1, 1'b1, 21'h0});
        strobe(1'b0, 1999, 1'b0);
        check_lit("R8 full scale", {1'b0, 1'b1, 7'h6F, 7'h6F, 7'h6F});

        finish_run();
    end
endmodule